// File: doc/BRIEF.md
# Five-Stage Stalling Integer Pipeline

This block is a small in-order integer core with five stages: fetch, decode with register read, execute, memory access and write-back. It runs four instructions: register add, signed set-less-than against an immediate, word load and word store. Instruction and data storage are word arrays inside the block. A single word-loading stream fills either array while the core is stopped. Each stage advances one step per clock. Some instructions leave a stage idle: add and set-less-than do nothing in the memory stage, and a store writes no register at write-back.

There are no forwarding paths. Suppose an instruction in decode needs a register that an older instruction in execute or memory access has not yet written back. The fetch/decode register and the PC then hold, and a bubble enters execute until the producer reaches write-back. The register file passes a same-cycle write-back through to its read ports, so a dependent instruction waits at most two cycles.

For control and observation the block has a plain `run` level, the current fetch PC, a one-cycle retire pulse and a combinational register read-back port. The loader is valid/ready. A word transfers on every rising clock edge where `ld_valid` and `ld_ready` are both high. `ld_ready` is high only while `run` is low and no instruction is in flight, so the source must hold its word until it is accepted.

Top module: `pipe5_core`

## Requirements
- R1: After reset the PC reads 0, the retire pulse is low, the loader is ready and every register reads 0.
- R2: While `run` is high and decode is not stalled, each clock fetches the word at PC/4 and advances the PC by 4; while `run` is low or decode is stalled, the PC holds.
- R3: Add (bits 31:26 = 0x00, bits 5:0 = 0x20) writes rs (bits 25:21) plus rt (bits 20:16) into rd (bits 15:11), modulo 2^32.
- R4: Set-less-than-immediate (opcode 0x0A) writes 1 into rt when rs, taken as signed, is below the sign-extended 16-bit immediate (bits 15:0), otherwise 0.
- R5: Load (opcode 0x23) reads the data word at index ((rs + sign-extended offset) / 4) modulo the data depth and writes it into rt.
- R6: Store (opcode 0x2B) writes the value of rt into the data word addressed as in R5 and changes no register.
- R7: An instruction that reads a register still being produced by an older instruction in execute or memory access is held in decode. For each held cycle one bubble enters execute. A consumer placed directly after its producer retires 3 cycles after it, and an independent instruction retires 1 cycle after its predecessor.
- R8: Register 0 always reads 0, even when written. A word with any other opcode, or with opcode 0 and a function field other than 0x20, changes nothing and does not retire.
- R9: `ld_ready` is high only while `run` is low and the pipeline is empty. An accepted word goes to data memory when `ld_to_dmem` is 1, otherwise to instruction memory, at word index `ld_addr`.
- R10: `dbg_retire` pulses once for each add, set-less-than, load or store leaving write-back, in program order. `dbg_reg_data` shows the register chosen by `dbg_reg_sel` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Fetch enable; low lets the pipeline drain |
| ld_valid | input | 1 | Loader word is valid |
| ld_ready | output | 1 | Loader can accept a word |
| ld_to_dmem | input | 1 | 1 selects data memory, 0 instruction memory |
| ld_addr | input | LAW (6) | Word index for the loader |
| ld_data | input | 32 | Word to store |
| dbg_pc | output | 32 | Current fetch PC |
| dbg_retire | output | 1 | One pulse per retired instruction |
| dbg_reg_sel | input | 5 | Register number to observe |
| dbg_reg_data | output | 32 | Value of the selected register |

## Verification
A missed interlock, or a stage register that fails to hold during a stall, lets a consumer read a stale register. The result is wrong in that consumer's destination register, which shows at the read-back port once the pipeline drains, and in every later result that depends on it. A stall that lasts too long or too short shows at once, in the spacing of retire pulses and in the PC stepping. A dropped or unrecognised instruction shows as a missing retire pulse within five cycles of its fetch.

// File: rtl/pipe5_pkg.sv
`timescale 1ns/1ps
package pipe5_pkg;
  localparam int XLEN  = 32;
  localparam int NREGS = 32;
  localparam int RAW   = $clog2(NREGS);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] FN_ADD   = 6'h20;
  localparam logic [5:0] OP_SLTI  = 6'h0A;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  typedef enum logic [2:0] {K_NOP, K_ADD, K_SLTI, K_LW, K_SW} kind_e;

  typedef struct packed {
    kind_e           kind;
    logic [RAW-1:0]  rs;
    logic [RAW-1:0]  rt;
    logic [RAW-1:0]  dst;
    logic            use_rs;
    logic            use_rt;
    logic            wen;
    logic [XLEN-1:0] imm;
  } dec_t;

  function automatic dec_t decode(input logic [XLEN-1:0] w);
    dec_t d;
    d        = '0;
    d.kind   = K_NOP;
    d.rs     = w[25:21];
    d.rt     = w[20:16];
    d.imm    = {{(XLEN-16){w[15]}}, w[15:0]};
    unique case (w[31:26])
      OP_RTYPE: if (w[5:0] == FN_ADD) begin
        d.kind = K_ADD; d.use_rs = 1'b1; d.use_rt = 1'b1;
        d.wen = 1'b1;   d.dst = w[15:11];
      end
      OP_SLTI: begin
        d.kind = K_SLTI; d.use_rs = 1'b1; d.wen = 1'b1; d.dst = w[20:16];
      end
      OP_LW: begin
        d.kind = K_LW; d.use_rs = 1'b1; d.wen = 1'b1; d.dst = w[20:16];
      end
      OP_SW: begin
        d.kind = K_SW; d.use_rs = 1'b1; d.use_rt = 1'b1;
      end
      default: ;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/p5_wordmem.sv
`timescale 1ns/1ps
module p5_wordmem #(
  parameter int WORDS = 64,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/p5_regfile.sv
`timescale 1ns/1ps
module p5_regfile
  import pipe5_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [RAW-1:0]  waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RAW-1:0]  ra_a,
  output logic [XLEN-1:0] rd_a,
  input  logic [RAW-1:0]  ra_b,
  output logic [XLEN-1:0] rd_b,
  input  logic [RAW-1:0]  ra_dbg,
  output logic [XLEN-1:0] rd_dbg
);
  logic [XLEN-1:0] regs [NREGS];
  logic            wr_ok;

  assign wr_ok = we && (waddr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_ok) begin
      regs[waddr] <= wdata;
    end
  end

  // same-cycle write-back is passed straight to the decode read ports
  function automatic logic [XLEN-1:0] rd_bypass(input logic [RAW-1:0] a);
    if (a == '0)                  return '0;
    else if (wr_ok && waddr == a) return wdata;
    else                          return regs[a];
  endfunction

  assign rd_a   = rd_bypass(ra_a);
  assign rd_b   = rd_bypass(ra_b);
  assign rd_dbg = (ra_dbg == '0) ? '0 : regs[ra_dbg];
endmodule

// File: rtl/p5_hazard.sv
`timescale 1ns/1ps
module p5_hazard
  import pipe5_pkg::*;
#(
  parameter int NWATCH = 2
) (
  input  logic                  fd_valid,
  input  dec_t                  dec,
  input  logic [NWATCH-1:0]     prod_wen,
  input  logic [NWATCH*RAW-1:0] prod_dst,
  output logic                  stall
);
  logic [NWATCH-1:0] hit;

  for (genvar g = 0; g < NWATCH; g++) begin : g_watch
    logic [RAW-1:0] d;
    assign d = prod_dst[g*RAW +: RAW];
    assign hit[g] = prod_wen[g] && (d != '0) &&
                    ((dec.use_rs && dec.rs == d) || (dec.use_rt && dec.rt == d));
  end

  assign stall = fd_valid && (dec.kind != K_NOP) && (|hit);
endmodule

// File: rtl/pipe5_core.sv
`timescale 1ns/1ps
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            ld_valid,
  output logic            ld_ready,
  input  logic            ld_to_dmem,
  input  logic [LAW-1:0]  ld_addr,
  input  logic [31:0]     ld_data,
  output logic [31:0]     dbg_pc,
  output logic            dbg_retire,
  input  logic [4:0]      dbg_reg_sel,
  output logic [31:0]     dbg_reg_data
);
  // fetch
  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] imem_rdata;
  // fetch/decode
  logic            fd_valid;
  logic [XLEN-1:0] fd_instr;
  dec_t            fd_dec;
  logic            stall;
  logic [XLEN-1:0] rf_a, rf_b;
  // decode/execute
  logic            de_valid;
  kind_e           de_kind;
  logic [XLEN-1:0] de_a, de_b, de_imm;
  logic [RAW-1:0]  de_dst;
  logic            de_wen;
  logic [XLEN-1:0] ex_res;
  // execute/memory
  logic            em_valid;
  kind_e           em_kind;
  logic [XLEN-1:0] em_res, em_sdata;
  logic [RAW-1:0]  em_dst;
  logic            em_wen;
  logic [XLEN-1:0] dmem_rdata;
  // memory/write-back
  logic            mw_valid;
  logic [XLEN-1:0] mw_val;
  logic [RAW-1:0]  mw_dst;
  logic            mw_wen;
  // loader and memory write steering
  logic            ld_fire;
  logic            st_fire;
  logic            dmem_we;
  logic [DAW-1:0]  dmem_waddr;
  logic [XLEN-1:0] dmem_wdata;

  assign ld_ready = !run && !fd_valid && !de_valid && !em_valid && !mw_valid;
  assign ld_fire  = ld_valid && ld_ready;
  assign st_fire  = em_valid && (em_kind == K_SW);

  assign dmem_we    = st_fire || (ld_fire && ld_to_dmem);
  assign dmem_waddr = st_fire ? em_res[2 +: DAW] : ld_addr[DAW-1:0];
  assign dmem_wdata = st_fire ? em_sdata : ld_data;

  p5_wordmem #(.WORDS(IMEM_WORDS), .WIDTH(XLEN)) imem_i (
    .clk(clk), .we(ld_fire && !ld_to_dmem), .waddr(ld_addr[IAW-1:0]),
    .wdata(ld_data), .raddr(pc[2 +: IAW]), .rdata(imem_rdata)
  );

  p5_wordmem #(.WORDS(DMEM_WORDS), .WIDTH(XLEN)) dmem_i (
    .clk(clk), .we(dmem_we), .waddr(dmem_waddr), .wdata(dmem_wdata),
    .raddr(em_res[2 +: DAW]), .rdata(dmem_rdata)
  );

  // ---------------- fetch ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc       <= '0;
      fd_valid <= 1'b0;
      fd_instr <= '0;
    end else if (!stall) begin
      if (run) pc <= pc + 32'd4;
      fd_valid <= run;
      fd_instr <= imem_rdata;
    end
  end

  // ---------------- decode ----------------
  assign fd_dec = decode(fd_instr);

  p5_regfile rf_i (
    .clk(clk), .rst_n(rst_n),
    .we(mw_valid && mw_wen), .waddr(mw_dst), .wdata(mw_val),
    .ra_a(fd_dec.rs), .rd_a(rf_a),
    .ra_b(fd_dec.rt), .rd_b(rf_b),
    .ra_dbg(dbg_reg_sel), .rd_dbg(dbg_reg_data)
  );

  p5_hazard #(.NWATCH(2)) hz_i (
    .fd_valid(fd_valid), .dec(fd_dec),
    .prod_wen({em_valid && em_wen, de_valid && de_wen}),
    .prod_dst({em_dst, de_dst}),
    .stall(stall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_valid <= 1'b0;
      de_kind  <= K_NOP;
      de_a     <= '0;
      de_b     <= '0;
      de_imm   <= '0;
      de_dst   <= '0;
      de_wen   <= 1'b0;
    end else begin
      de_valid <= fd_valid && !stall && (fd_dec.kind != K_NOP);
      de_kind  <= (fd_valid && !stall) ? fd_dec.kind : K_NOP;
      de_wen   <= fd_valid && !stall && fd_dec.wen;
      de_a     <= rf_a;
      de_b     <= rf_b;
      de_imm   <= fd_dec.imm;
      de_dst   <= fd_dec.dst;
    end
  end

  // ---------------- execute ----------------
  always_comb begin
    unique case (de_kind)
      K_ADD:       ex_res = de_a + de_b;
      K_SLTI:      ex_res = ($signed(de_a) < $signed(de_imm)) ? 32'd1 : 32'd0;
      K_LW, K_SW:  ex_res = de_a + de_imm;
      default:     ex_res = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      em_valid <= 1'b0;
      em_kind  <= K_NOP;
      em_res   <= '0;
      em_sdata <= '0;
      em_dst   <= '0;
      em_wen   <= 1'b0;
    end else begin
      em_valid <= de_valid;
      em_kind  <= de_kind;
      em_res   <= ex_res;
      em_sdata <= de_b;
      em_dst   <= de_dst;
      em_wen   <= de_valid && de_wen;
    end
  end

  // ---------------- memory access ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mw_valid <= 1'b0;
      mw_val   <= '0;
      mw_dst   <= '0;
      mw_wen   <= 1'b0;
    end else begin
      mw_valid <= em_valid;
      mw_val   <= (em_kind == K_LW) ? dmem_rdata : em_res;
      mw_dst   <= em_dst;
      mw_wen   <= em_valid && em_wen;
    end
  end

  // ---------------- write-back / debug ----------------
  assign dbg_retire = mw_valid;
  assign dbg_pc     = pc;
endmodule

// File: rtl/pipe5_core_chk.sv
`timescale 1ns/1ps
module pipe5_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic        stall,
  input logic [31:0] pc,
  input logic        de_valid,
  input logic        ld_ready,
  input logic [4:0]  dbg_reg_sel,
  input logic [31:0] dbg_reg_data
);
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(run) && !$past(stall)) |-> (pc == $past(pc) + 32'd4));

  p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (!$past(run) || $past(stall))) |-> (pc == $past(pc)));

  p_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !de_valid);

  p_zero_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_reg_sel == 5'd0) |-> (dbg_reg_data == 32'd0));

  p_ld_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready |-> !run);
endmodule

bind pipe5_core pipe5_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .stall(stall), .pc(pc),
  .de_valid(de_valid), .ld_ready(ld_ready),
  .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(dbg_reg_data)
);

// File: tb/pipe5_core_tb_top.sv
`timescale 1ns/1ps
module pipe5_core_tb_top;
  localparam int IW = 64;
  localparam int DW = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic        ld_to_dmem = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] dbg_pc;
  logic        dbg_retire;
  logic [4:0]  dbg_reg_sel = '0;
  logic [31:0] dbg_reg_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pipe5_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_to_dmem(ld_to_dmem), .ld_addr(ld_addr), .ld_data(ld_data),
    .dbg_pc(dbg_pc), .dbg_retire(dbg_retire),
    .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(dbg_reg_data)
  );

  // ---------- reference model ----------
  logic [31:0] prog  [IW];
  logic [31:0] m_reg [32];
  logic [31:0] m_mem [DW];
  int          m_retired;
  int          ret_cyc [256];
  int          nret;
  int          cyc;

  function automatic logic [31:0] e_add(logic [4:0] d, logic [4:0] s, logic [4:0] t);
    return {6'h00, s, t, d, 5'd0, 6'h20};
  endfunction
  function automatic logic [31:0] e_slti(logic [4:0] t, logic [4:0] s, logic [15:0] im);
    return {6'h0A, s, t, im};
  endfunction
  function automatic logic [31:0] e_lw(logic [4:0] t, logic [4:0] b, logic [15:0] off);
    return {6'h23, b, t, off};
  endfunction
  function automatic logic [31:0] e_sw(logic [4:0] t, logic [4:0] b, logic [15:0] off);
    return {6'h2B, b, t, off};
  endfunction

  function automatic void m_step(logic [31:0] w);
    logic [31:0] sx, a, b, ea;
    int idx;
    sx = {{16{w[15]}}, w[15:0]};
    a  = m_reg[w[25:21]];
    b  = m_reg[w[20:16]];
    ea = a + sx;
    idx = int'(ea[31:2]) % DW;
    if (idx < 0) idx = idx + DW;
    if (w[31:26] == 6'h00 && w[5:0] == 6'h20) begin
      if (w[15:11] != 0) m_reg[w[15:11]] = a + b;
      m_retired++;
    end else if (w[31:26] == 6'h0A) begin
      if (w[20:16] != 0) m_reg[w[20:16]] = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
      m_retired++;
    end else if (w[31:26] == 6'h23) begin
      if (w[20:16] != 0) m_reg[w[20:16]] = m_mem[idx];
      m_retired++;
    end else if (w[31:26] == 6'h2B) begin
      m_mem[idx] = b;
      m_retired++;
    end
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    run = 0; ld_valid = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int r = 0; r < 32; r++) m_reg[r] = '0;
    m_retired = 0;
  endtask

  task automatic load_word(bit to_d, int a, logic [31:0] d);
    @(negedge clk);
    ld_valid = 1; ld_to_dmem = to_d; ld_addr = 6'(a); ld_data = d;
    if (!ld_ready) begin
      checks++; errors++;
      $display("FAIL R9 actual=%0d expected=1 (ld_ready while idle)", ld_ready);
    end
    @(posedge clk);
    #1 ld_valid = 0;
  endtask

  task automatic load_all(int len);
    for (int i = 0; i < IW; i++) load_word(0, i, (i < len) ? prog[i] : 32'h0);
    for (int i = 0; i < DW; i++) load_word(1, i, m_mem[i]);
  endtask

  task automatic run_prog(int len);
    logic [31:0] hold_pc;
    int lim;
    nret = 0; cyc = 0;
    @(negedge clk);
    run = 1;
    @(negedge clk); cyc++;
    check("R2 first step", dbg_pc, 32'd4);
    check("R9 ready low while running", 32'(ld_ready), 32'd0);
    if (dbg_retire) begin ret_cyc[nret] = cyc; nret++; end
    @(negedge clk); cyc++;
    check("R2 second step", dbg_pc, 32'd8);
    lim = 0;
    while (dbg_pc != 32'(4 * len) && lim < len * 4 + 20) begin
      if (dbg_retire && nret < 256) begin ret_cyc[nret] = cyc; nret++; end
      @(negedge clk); cyc++; lim++;
    end
    if (dbg_retire && nret < 256) begin ret_cyc[nret] = cyc; nret++; end
    run = 0;
    hold_pc = dbg_pc;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); cyc++;
      if (dbg_retire && nret < 256) begin ret_cyc[nret] = cyc; nret++; end
    end
    check("R2 pc held with run low", dbg_pc, hold_pc);
    check("R9 ready after drain", 32'(ld_ready), 32'd1);
    for (int i = 0; i < len; i++) m_step(prog[i]);
    check("R10 retire count", 32'(nret), 32'(m_retired));
  endtask

  task automatic read_reg(int r, output logic [31:0] v);
    @(negedge clk);
    dbg_reg_sel = 5'(r);
    #2 v = dbg_reg_data;
  endtask

  task automatic cmp_all_regs(string tag);
    logic [31:0] v;
    for (int r = 0; r < 32; r++) begin
      read_reg(r, v);
      check(tag, v, m_reg[r]);
    end
  endtask

  // ---------- watchdog ----------
  initial begin
    #(64'd200000 * 64'd20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------- main ----------
  initial begin
    logic [31:0] v;
    int len;
    void'($urandom(32'd20240611));
    do_reset();

    // R1 reset state
    check("R1 pc", dbg_pc, 32'd0);
    check("R1 retire", 32'(dbg_retire), 32'd0);
    check("R1 ld_ready", 32'(ld_ready), 32'd1);
    for (int r = 0; r < 32; r++) begin
      read_reg(r, v);
      check("R1 reg zero", v, 32'd0);
    end

    // ---- directed program ----
    for (int i = 0; i < DW; i++) m_mem[i] = 32'(i * 3);
    m_mem[2] = 32'h8000_0000;
    prog[0] = e_slti(5'd1, 5'd0, 16'd5);     // r1 = 1
    prog[1] = e_add (5'd2, 5'd1, 5'd1);      // r2 = 2, waits on r1
    prog[2] = e_slti(5'd3, 5'd0, 16'hFFFF);  // 0 < -1 ? -> 0
    prog[3] = e_lw  (5'd4, 5'd0, 16'd8);     // r4 = mem[2]
    prog[4] = e_slti(5'd5, 5'd4, 16'd5);     // negative < 5 -> 1
    prog[5] = e_sw  (5'd4, 5'd1, 16'd12);    // mem[3] = r4
    prog[6] = e_lw  (5'd6, 5'd0, 16'd12);    // r6 = mem[3]
    prog[7] = e_add (5'd0, 5'd1, 5'd1);      // write to r0 dropped
    prog[8] = 32'hFC00_0000;                 // unknown opcode
    prog[9] = {6'h00, 5'd1, 5'd1, 5'd7, 5'd0, 6'h22}; // opcode 0, other funct
    len = 10;
    load_all(len);
    run_prog(len);
    check("R7 dependent retire gap", 32'(ret_cyc[1] - ret_cyc[0]), 32'd3);
    check("R7 independent retire gap", 32'(ret_cyc[2] - ret_cyc[1]), 32'd1);
    check("R10 retire count directed", 32'(nret), 32'd8);
    read_reg(1, v); check("R4 slti true", v, 32'd1);
    read_reg(2, v); check("R3 add after stall", v, 32'd2);
    read_reg(3, v); check("R4 signed imm", v, 32'd0);
    read_reg(4, v); check("R5 load", v, 32'h8000_0000);
    read_reg(5, v); check("R4 signed compare", v, 32'd1);
    read_reg(6, v); check("R6 store then load", v, 32'h8000_0000);
    read_reg(0, v); check("R8 r0 stays zero", v, 32'd0);
    read_reg(7, v); check("R8 unknown funct ignored", v, 32'd0);
    cmp_all_regs("R6 no stray register write");

    // ---- constrained random programs ----
    for (int rnd = 0; rnd < 4; rnd++) begin
      do_reset();
      len = 48;
      for (int i = 0; i < DW; i++) m_mem[i] = $urandom;
      for (int i = 0; i < len; i++) begin
        logic [4:0]  a, b, c;
        logic [15:0] im;
        int sel;
        a = 5'($urandom % 8); b = 5'($urandom % 8); c = 5'($urandom % 8);
        im = 16'($urandom);
        sel = $urandom % 10;
        case (sel)
          0, 1, 2: prog[i] = e_add(a, b, c);
          3, 4:    prog[i] = e_slti(a, b, im);
          5, 6:    prog[i] = e_lw(a, b, im);
          7, 8:    prog[i] = e_sw(a, b, im);
          default: prog[i] = ($urandom % 2 == 0) ? {6'h3E, 26'($urandom)} : e_add(5'd0, b, c);
        endcase
      end
      load_all(len);
      run_prog(len);
      cmp_all_regs("R3 R4 R5 R6 R7 R8 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule